// File: doc/BRIEF.md
# Grouped Software Flag Register

This block keeps a bank of single-bit software flags for a small nibble-wide controller core. The core hands it one decoded byte per cycle together with a valid strobe. Two opcode patterns act on the bank. In both, the low nibble names the flag. One pattern forces that flag high and the other forces it low. Any other byte leaves the bank alone.

A clear operation also refreshes a zero indicator. The indicator is not taken from the addressed bit alone, nor from the whole bank. It is taken from the aligned group of flags that holds the addressed bit, as that group reads after the clear. With the default sizes there are sixteen flags in four groups of four. The flag vector and the zero indicator are both registered, so each operation becomes visible one clock after it is accepted. Operations may follow each other on every cycle.

Top module: `grouped_flag_unit`

## Requirements
- R1: A synchronous active-high reset drives every flag and the zero indicator to 0.
- R2: With the strobe high, an opcode whose upper nibble is 0101 sets the flag numbered by the lower nibble to 1 at the next clock edge.
- R3: With the strobe high, an opcode whose upper nibble is 0001 clears the flag numbered by the lower nibble to 0 at the next clock edge.
- R4: A set or clear operation changes no flag other than the addressed one.
- R5: After a clear operation on flag b, the zero indicator is 1 exactly when every flag in the aligned group containing b is 0. That group runs from index (b / GROUP) * GROUP through that index + GROUP - 1. Flags outside the group have no influence on the indicator.
- R6: A set operation leaves the zero indicator unchanged.
- R7: When the strobe is low, or the upper nibble is neither 0101 nor 0001, the flags and the zero indicator keep their values.
- R8: A set or clear operation whose lower nibble is not below the flag count has no effect on the flags or on the zero indicator.
- R9: Operations accepted on consecutive cycles each take effect one clock after they are accepted, and none is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies op_code for this cycle |
| op_code | input | 8 | Instruction byte: upper nibble is the operation, lower nibble is the flag number |
| flags_o | output | FLAG_NUM | Registered flag bank, bit i is flag i |
| zero_o | output | 1 | Registered group-zero indicator |

## Verification
The bench builds two copies from the same stimulus stream. The first uses the defaults: sixteen flags in groups of four. The second uses eight flags in groups of two. In the second copy, lower nibbles 8 to 15 fall outside the bank, so the out-of-range rule can be checked. Its narrower groups also give a different set of group boundaries for the zero indicator. Directed cases clear a flag while a flag in another group stays set, and the random stream mixes sets, clears, foreign bytes and idle cycles.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  localparam int OPC_W      = 8;
  localparam int FIELD_W    = 4;
  localparam int PREFIX_W   = OPC_W - FIELD_W;

  localparam logic [PREFIX_W-1:0] SET_PREFIX = 4'b0101;
  localparam logic [PREFIX_W-1:0] CLR_PREFIX = 4'b0001;

  typedef enum logic [1:0] {
    FOP_NONE = 2'd0,
    FOP_SET  = 2'd1,
    FOP_CLR  = 2'd2
  } flag_op_e;

endpackage

// File: rtl/flag_opc_decode.sv
module flag_opc_decode
  import flag_unit_pkg::*;
#(
  parameter int FLAG_NUM = 16,
  localparam int IDX_W   = $clog2(FLAG_NUM)
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  output flag_op_e         op_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [PREFIX_W-1:0] prefix;
  logic [FIELD_W-1:0]  field;
  logic                in_range;

  assign prefix   = opcode_i[OPC_W-1:FIELD_W];
  assign field    = opcode_i[FIELD_W-1:0];
  assign in_range = (32'(field) < FLAG_NUM);
  assign idx_o    = field[IDX_W-1:0];

  always_comb begin
    op_o = FOP_NONE;
    if (valid_i && in_range) begin
      if (prefix == SET_PREFIX)      op_o = FOP_SET;
      else if (prefix == CLR_PREFIX) op_o = FOP_CLR;
    end
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_unit_pkg::*;
#(
  parameter int FLAG_NUM = 16,
  localparam int IDX_W   = $clog2(FLAG_NUM)
) (
  input  logic                clk,
  input  logic                rst,
  input  flag_op_e            op_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [FLAG_NUM-1:0] flags_q,
  output logic [FLAG_NUM-1:0] flags_nxt
);

  for (genvar i = 0; i < FLAG_NUM; i++) begin : g_bit
    logic hit;
    assign hit = (idx_i == IDX_W'(i));

    always_comb begin
      flags_nxt[i] = flags_q[i];
      if (hit && op_i == FOP_SET) flags_nxt[i] = 1'b1;
      if (hit && op_i == FOP_CLR) flags_nxt[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_nxt[i];
    end
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    (op_i == FOP_SET) |=> flags_q[$past(idx_i)] == 1'b1); // R2

  AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (op_i == FOP_CLR) |=> flags_q[$past(idx_i)] == 1'b0); // R3

  AST_SINGLE_BIT_MOVE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(flags_q ^ $past(flags_q)) <= 1); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op_i == FOP_NONE) |=> $stable(flags_q)); // R7

endmodule

// File: rtl/flag_group_zero.sv
module flag_group_zero
  import flag_unit_pkg::*;
#(
  parameter int FLAG_NUM  = 16,
  parameter int GRP_SIZE  = 4,
  localparam int IDX_W    = $clog2(FLAG_NUM),
  localparam int GRP_NUM  = FLAG_NUM / GRP_SIZE,
  localparam int LOG_GS   = $clog2(GRP_SIZE),
  localparam int SEL_W    = IDX_W - LOG_GS
) (
  input  logic                clk,
  input  logic                rst,
  input  flag_op_e            op_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [FLAG_NUM-1:0] flags_nxt_i,
  output logic                zero_q
);

  logic [GRP_NUM-1:0] grp_empty;
  logic [SEL_W-1:0]   grp_sel;

  for (genvar g = 0; g < GRP_NUM; g++) begin : g_grp
    assign grp_empty[g] = ~|flags_nxt_i[g*GRP_SIZE +: GRP_SIZE];
  end

  assign grp_sel = idx_i[IDX_W-1:LOG_GS];

  always_ff @(posedge clk) begin
    if (rst)                  zero_q <= 1'b0;
    else if (op_i == FOP_CLR) zero_q <= grp_empty[grp_sel];
  end

  AST_ZF_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (rst)
    (op_i != FOP_CLR) |=> $stable(zero_q)); // R6

endmodule

// File: rtl/grouped_flag_unit.sv
module grouped_flag_unit
  import flag_unit_pkg::*;
#(
  parameter int FLAG_NUM = 16,
  parameter int GRP_SIZE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [7:0]          op_code,
  output logic [FLAG_NUM-1:0] flags_o,
  output logic                zero_o
);

  localparam int IDX_W = $clog2(FLAG_NUM);

  flag_op_e            dec_op;
  logic [IDX_W-1:0]    dec_idx;
  logic [FLAG_NUM-1:0] flags_nxt;
  logic [FLAG_NUM-1:0] grp_mask;

  flag_opc_decode #(.FLAG_NUM(FLAG_NUM)) u_decode (
    .valid_i  (op_valid),
    .opcode_i (op_code),
    .op_o     (dec_op),
    .idx_o    (dec_idx)
  );

  flag_store #(.FLAG_NUM(FLAG_NUM)) u_store (
    .clk       (clk),
    .rst       (rst),
    .op_i      (dec_op),
    .idx_i     (dec_idx),
    .flags_q   (flags_o),
    .flags_nxt (flags_nxt)
  );

  flag_group_zero #(.FLAG_NUM(FLAG_NUM), .GRP_SIZE(GRP_SIZE)) u_zero (
    .clk         (clk),
    .rst         (rst),
    .op_i        (dec_op),
    .idx_i       (dec_idx),
    .flags_nxt_i (flags_nxt),
    .zero_q      (zero_o)
  );

  assign grp_mask = {{(FLAG_NUM-GRP_SIZE){1'b0}}, {GRP_SIZE{1'b1}}}
                    << ((32'(dec_idx) / GRP_SIZE) * GRP_SIZE);

  AST_ZF_FROM_GROUP: assert property (@(posedge clk) disable iff (rst)
    (dec_op == FOP_CLR) |=> zero_o == ((flags_o & $past(grp_mask)) == '0)); // R5

  AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || (op_code[7:4] != 4'b0101 && op_code[7:4] != 4'b0001))
      |=> $stable(flags_o) && $stable(zero_o)); // R7

  AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (rst)
    (32'(op_code[3:0]) >= FLAG_NUM) |=> $stable(flags_o) && $stable(zero_o)); // R8

endmodule

// File: tb/grouped_flag_unit_bench.sv
module grouped_flag_unit_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [7:0]  op_code;
  logic [15:0] flags_a;
  logic        zero_a;
  logic [7:0]  flags_b;
  logic        zero_b;

  logic [15:0] mdl_fa;
  logic        mdl_za;
  logic [15:0] mdl_fb;
  logic        mdl_zb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_P/2) clk = ~clk;

  grouped_flag_unit u_grouped_flag_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .flags_o(flags_a), .zero_o(zero_a)
  );

  grouped_flag_unit #(.FLAG_NUM(8), .GRP_SIZE(2)) u_grouped_flag_unit_small (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .flags_o(flags_b), .zero_o(zero_b)
  );

  function automatic void ref_step(input logic v, input logic [7:0] op,
                                   input int n, input int g,
                                   inout logic [15:0] f, inout logic z);
    int b;
    int base;
    b = int'(op[3:0]);
    if (!v || b >= n) return;
    if (op[7:4] == 4'h5) f[b] = 1'b1;
    else if (op[7:4] == 4'h1) begin
      f[b] = 1'b0;
      base = (b / g) * g;
      z = 1'b1;
      for (int k = 0; k < g; k++) if (f[base+k]) z = 1'b0;
    end
  endfunction

  function automatic string tag_flags(input logic v, input logic [7:0] op, input int n);
    if (!v) return "R7";
    if (op[7:4] != 4'h5 && op[7:4] != 4'h1) return "R7";
    if (int'(op[3:0]) >= n) return "R8";
    return (op[7:4] == 4'h5) ? "R2 R4 R9" : "R3 R4 R9";
  endfunction

  function automatic string tag_zero(input logic v, input logic [7:0] op, input int n);
    if (!v) return "R7";
    if (op[7:4] != 4'h5 && op[7:4] != 4'h1) return "R7";
    if (int'(op[3:0]) >= n) return "R8";
    return (op[7:4] == 4'h5) ? "R6" : "R5";
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input logic v, input logic [7:0] op);
    chk({"wide flags ", tag_flags(v, op, 16)}, flags_a, mdl_fa);
    chk({"wide zero ",  tag_zero(v, op, 16)},  {15'd0, zero_a}, {15'd0, mdl_za});
    chk({"small flags ", tag_flags(v, op, 8)}, {8'd0, flags_b}, mdl_fb);
    chk({"small zero ",  tag_zero(v, op, 8)},  {15'd0, zero_b}, {15'd0, mdl_zb});
  endtask

  task automatic do_op(input logic v, input logic [7:0] op);
    @(negedge clk);
    op_valid = v;
    op_code  = op;
    ref_step(v, op, 16, 4, mdl_fa, mdl_za);
    ref_step(v, op, 8, 2, mdl_fb, mdl_zb);
    @(posedge clk);
    #1;
    compare_all(v, op);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    logic       v;
    int         pick;
    void'($urandom(32'd4242));
    rst = 1'b1; op_valid = 1'b0; op_code = 8'h00;
    mdl_fa = '0; mdl_za = 1'b0; mdl_fb = '0; mdl_zb = 1'b0;
    // Reset with a set opcode pending: reset must win (R1)
    @(negedge clk); op_valid = 1'b1; op_code = 8'h53;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 wide flags", flags_a, 16'h0);
    chk("R1 wide zero", {15'd0, zero_a}, 16'h0);
    chk("R1 small flags", {8'd0, flags_b}, 16'h0);
    chk("R1 small zero", {15'd0, zero_b}, 16'h0);
    @(negedge clk); rst = 1'b0; op_valid = 1'b0;

    // Directed corner cases
    do_op(1, 8'h55);   // set F5, zero unchanged (R6)
    do_op(1, 8'h15);   // clear F5, group 1 empty (R5)
    do_op(1, 8'h54);
    do_op(1, 8'h56);
    do_op(1, 8'h15);   // group still holds F4, F6
    do_op(1, 8'h14);
    do_op(1, 8'h16);   // group empties
    do_op(1, 8'h50);   // F0 set in another group
    do_op(1, 8'h17);   // clear F7: zero must ignore F0 (R5)
    do_op(0, 8'h10);   // strobe low (R7)
    do_op(1, 8'h3A);   // foreign byte (R7)
    do_op(1, 8'hF0);   // foreign byte (R7)
    do_op(1, 8'h5C);   // F12: out of range for eight flags (R8)
    do_op(1, 8'h1F);   // clear F15: small copy must ignore (R8)
    do_op(1, 8'h5D);
    do_op(1, 8'h1C);   // group 3 keeps F13
    do_op(1, 8'h1D);   // group 3 empties
    do_op(1, 8'h5F);
    do_op(1, 8'h5F);   // repeated set

    // Random back-to-back stream (R9)
    for (int i = 0; i < 400; i++) begin
      pick = int'($urandom_range(99));
      v    = ($urandom_range(9) != 0);
      if (pick < 45)      op = {4'h5, 4'($urandom_range(15))};
      else if (pick < 90) op = {4'h1, 4'($urandom_range(15))};
      else                op = 8'($urandom_range(255));
      do_op(v, op);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule